// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks the memory lines a lockup-free data cache has asked for and not yet received. It sits beside the cache of an in-order pipeline. A load that misses is handed to the block and leaves the pipeline at once. The block remembers which register waits for which word of the missing line, and it marks that register empty. Later loads that miss on the same line join the existing entry and send nothing new to memory. When the line comes back in a single wide fill, every waiting register gets its word in the same cycle and is marked full again.

The decode stage asks the block whether any of its source registers is still empty, and holds the instruction while that is so. The pipeline must stall a load that the block cannot take, and present it again later. That happens when the load needs a fresh entry and none is free, when its word already has a waiting register, when its own destination is still pending, or when its line is being filled in that very cycle. The cache arrays and the memory itself are outside the block.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free and every register is full. `miss_stall`, `dec_stall`, `mem_req_valid` and all bits of `wb_en` are low.
- R2: An accepted miss to a line that no valid entry holds takes the lowest-numbered free entry. In the next cycle `mem_req_valid` is high for exactly one cycle, with `mem_req_line` equal to the missed line and `mem_req_tag` equal to that entry's index.
- R3: An accepted miss to a line that a valid entry already holds records its destination register against the requested word of that entry. It produces no memory request.
- R4: A memory request is produced only by the allocation of a new entry. Merges, stalls, fills and idle cycles leave `mem_req_valid` low in the following cycle.
- R5: An accepted miss marks its destination register empty from the next cycle on. `dec_stall` is high in the same cycle whenever `dec_src_a` or `dec_src_b` names an empty register.
- R6: A miss to a held line whose requested word already has a waiting register is refused: `miss_stall` is high.
- R7: A miss to a line that no entry holds is refused while all entries are valid.
- R8: A fill whose `fill_tag` names a valid entry frees that entry and marks its waiting registers full. In the next cycle, for each word w that had a waiting register, `wb_en[w]` is 1 and `wb_reg[w*5 +: 5]` gives that register. `wb_data[w*32 +: 32]` equals `fill_data[w*32 +: 32]`, and all other `wb_en` bits are 0.
- R9: A fill whose `fill_tag` names a free entry is ignored: `wb_en` stays 0 in the next cycle and no register or entry changes.
- R10: A miss whose destination register is already empty is refused.
- R11: A miss to a line whose entry receives its fill in the same cycle is refused. The fill still completes as in R8.
- R12: A refused miss changes no entry, no register state and requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed in the cache this cycle |
| miss_line | input | 26 | Line address of the missing load |
| miss_word | input | 3 | Word within the line the load wants |
| miss_dest | input | 5 | Destination register of the load |
| miss_stall | output | 1 | Miss refused this cycle; the pipeline must hold and retry |
| mem_req_valid | output | 1 | One-cycle request for a whole line |
| mem_req_line | output | 26 | Line address being requested |
| mem_req_tag | output | 2 | Entry index that the fill must return |
| fill_valid | input | 1 | A whole line is returning from memory |
| fill_tag | input | 2 | Entry index the returning line belongs to |
| fill_data | input | 256 | Returning line, word w at bits w*32 upward |
| wb_en | output | 8 | Per-word register write enable |
| wb_reg | output | 40 | Per-word target register, 5 bits per word |
| wb_data | output | 256 | Per-word write data, 32 bits per word |
| dec_src_a | input | 5 | First source register of the instruction in decode |
| dec_src_b | input | 5 | Second source register of the instruction in decode |
| dec_stall | output | 1 | A source register in decode is still empty |

## Verification
The case where two functions collide is a fill and a miss to the same entry in the same cycle. The fill frees the entry and writes its registers, while the miss would add a waiting word to the same entry. The bench builds this case directly. It fills one entry while it offers a second load to that entry's line, and it expects the load to be refused. It expects the fill to complete fully and the entry to be reusable from the next cycle on. The random phase keeps drawing fills and misses over a small pool of lines, so the same collision recurs. Each outcome is judged against a reference model kept in the bench.

// File: rtl/mshr_cfg_pkg.sv
package mshr_cfg_pkg;

    // Default geometry of the miss tracking file.
    localparam int unsigned DEF_ENTRIES = 4;
    localparam int unsigned DEF_WORDS   = 8;
    localparam int unsigned DEF_REGS    = 32;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_LINE_AW = 26;

    // Outcome of a miss presented in one cycle.
    typedef enum logic [1:0] {
        MISS_IDLE   = 2'd0,
        MISS_NEW    = 2'd1,
        MISS_MERGE  = 2'd2,
        MISS_REFUSE = 2'd3
    } miss_kind_e;

endpackage

// File: rtl/mshr_line_match.sv
module mshr_line_match #(
    parameter int unsigned N_ENT   = 4,
    parameter int unsigned LINE_AW = 26,
    localparam int unsigned ENT_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]              ent_valid,
    input  logic [N_ENT-1:0][LINE_AW-1:0] ent_line,
    input  logic [LINE_AW-1:0]            probe_line,
    output logic                          hit,
    output logic [ENT_W-1:0]              hit_idx
);

    logic [N_ENT-1:0] hit_vec;

    // One comparator per entry.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_line[g] == probe_line);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) hit_idx = ENT_W'(i);
        end
    end

endmodule

// File: rtl/mshr_free_pick.sv
module mshr_free_pick #(
    parameter int unsigned N_ENT  = 4,
    localparam int unsigned ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] ent_valid,
    output logic             any_free,
    output logic [ENT_W-1:0] free_idx
);

    // Lowest-numbered free entry wins: scan downward so the last write is the lowest.
    always_comb begin
        any_free = ~&ent_valid;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = ENT_W'(i);
        end
    end

endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
    parameter int unsigned N_REGS = 32,
    localparam int unsigned REG_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_reg,
    input  logic [N_REGS-1:0] clr_mask,
    input  logic [REG_W-1:0]  qry_a,
    input  logic [REG_W-1:0]  qry_b,
    input  logic [REG_W-1:0]  qry_dest,
    output logic [N_REGS-1:0] empty_vec,
    output logic              src_empty,
    output logic              dest_empty
);

    logic [N_REGS-1:0] empty_d, empty_q;

    always_comb begin
        empty_d = empty_q & ~clr_mask;
        if (set_en) empty_d[set_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) empty_q <= '0;
        else        empty_q <= empty_d;
    end

    assign empty_vec  = empty_q;
    assign src_empty  = empty_q[qry_a] | empty_q[qry_b];
    assign dest_empty = empty_q[qry_dest];

    // R5: a register marked by an accepted miss reads empty on the next cycle.
    a_r5_set_marks_empty: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> empty_q[$past(set_reg)]);

    // R8: registers written by a fill read full on the next cycle.
    a_r8_clear_marks_full: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((empty_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_cfg_pkg::*;
#(
    parameter int unsigned N_ENT   = DEF_ENTRIES,
    parameter int unsigned N_WORDS = DEF_WORDS,
    parameter int unsigned N_REGS  = DEF_REGS,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned LINE_AW = DEF_LINE_AW,
    localparam int unsigned ENT_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int unsigned WORD_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int unsigned REG_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_valid,
    input  logic [LINE_AW-1:0]          miss_line,
    input  logic [WORD_W-1:0]           miss_word,
    input  logic [REG_W-1:0]            miss_dest,
    output logic                        miss_stall,
    output logic                        mem_req_valid,
    output logic [LINE_AW-1:0]          mem_req_line,
    output logic [ENT_W-1:0]            mem_req_tag,
    input  logic                        fill_valid,
    input  logic [ENT_W-1:0]            fill_tag,
    input  logic [N_WORDS*DATA_W-1:0]   fill_data,
    output logic [N_WORDS-1:0]          wb_en,
    output logic [N_WORDS*REG_W-1:0]    wb_reg,
    output logic [N_WORDS*DATA_W-1:0]   wb_data,
    input  logic [REG_W-1:0]            dec_src_a,
    input  logic [REG_W-1:0]            dec_src_b,
    output logic                        dec_stall
);

    typedef struct packed {
        logic [N_ENT-1:0]                          valid;
        logic [N_ENT-1:0][LINE_AW-1:0]             line;
        logic [N_ENT-1:0][N_WORDS-1:0]             slot_v;
        logic [N_ENT-1:0][N_WORDS-1:0][REG_W-1:0]  slot_reg;
        logic                                      req_v;
        logic [LINE_AW-1:0]                        req_line;
        logic [ENT_W-1:0]                          req_tag;
        logic [N_WORDS-1:0]                        wb_en;
        logic [N_WORDS-1:0][REG_W-1:0]             wb_reg;
        logic [N_WORDS-1:0][DATA_W-1:0]            wb_data;
    } state_t;

    state_t st_d, st_q;

    logic              hit;
    logic [ENT_W-1:0]  hit_idx;
    logic              any_free;
    logic [ENT_W-1:0]  free_idx;
    logic              dest_empty;
    logic              src_empty;
    logic [N_REGS-1:0] empty_vec;
    logic [N_REGS-1:0] clr_mask;
    logic              fill_live;
    logic              slot_busy;
    logic              hit_filling;
    miss_kind_e        kind;

    mshr_line_match #(.N_ENT(N_ENT), .LINE_AW(LINE_AW)) u_match (
        .ent_valid  (st_q.valid),
        .ent_line   (st_q.line),
        .probe_line (miss_line),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    mshr_free_pick #(.N_ENT(N_ENT)) u_pick (
        .ent_valid (st_q.valid),
        .any_free  (any_free),
        .free_idx  (free_idx)
    );

    mshr_scoreboard #(.N_REGS(N_REGS)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (kind == MISS_NEW || kind == MISS_MERGE),
        .set_reg    (miss_dest),
        .clr_mask   (clr_mask),
        .qry_a      (dec_src_a),
        .qry_b      (dec_src_b),
        .qry_dest   (miss_dest),
        .empty_vec  (empty_vec),
        .src_empty  (src_empty),
        .dest_empty (dest_empty)
    );

    // Classify the presented miss.
    always_comb begin
        fill_live   = fill_valid && st_q.valid[fill_tag];
        slot_busy   = st_q.slot_v[hit_idx][miss_word];
        hit_filling = fill_live && (fill_tag == hit_idx);
        if (!miss_valid)                         kind = MISS_IDLE;
        else if (dest_empty)                     kind = MISS_REFUSE;
        else if (hit && (slot_busy || hit_filling)) kind = MISS_REFUSE;
        else if (hit)                            kind = MISS_MERGE;
        else if (!any_free)                      kind = MISS_REFUSE;
        else                                     kind = MISS_NEW;
    end

    // Next-state computation.
    always_comb begin
        st_d       = st_q;
        st_d.req_v = 1'b0;
        st_d.wb_en = '0;
        clr_mask   = '0;

        if (fill_live) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (st_q.slot_v[fill_tag][w]) begin
                    st_d.wb_en[w]   = 1'b1;
                    st_d.wb_reg[w]  = st_q.slot_reg[fill_tag][w];
                    st_d.wb_data[w] = fill_data[w*DATA_W +: DATA_W];
                    clr_mask[st_q.slot_reg[fill_tag][w]] = 1'b1;
                end
            end
            st_d.valid[fill_tag]  = 1'b0;
            st_d.slot_v[fill_tag] = '0;
        end

        unique case (kind)
            MISS_MERGE: begin
                st_d.slot_v[hit_idx][miss_word]   = 1'b1;
                st_d.slot_reg[hit_idx][miss_word] = miss_dest;
            end
            MISS_NEW: begin
                st_d.valid[free_idx]              = 1'b1;
                st_d.line[free_idx]               = miss_line;
                st_d.slot_v[free_idx]             = '0;
                st_d.slot_v[free_idx][miss_word]  = 1'b1;
                st_d.slot_reg[free_idx][miss_word] = miss_dest;
                st_d.req_v                        = 1'b1;
                st_d.req_line                     = miss_line;
                st_d.req_tag                      = free_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss_stall    = (kind == MISS_REFUSE);
    assign dec_stall     = src_empty;
    assign mem_req_valid = st_q.req_v;
    assign mem_req_line  = st_q.req_line;
    assign mem_req_tag   = st_q.req_tag;
    assign wb_en         = st_q.wb_en;
    assign wb_reg        = st_q.wb_reg;
    assign wb_data       = st_q.wb_data;

    // R4: a request follows only a miss that found no holding entry and was taken.
    a_r4_req_only_on_new: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(miss_valid && !miss_stall && !hit));

    // R2: the tag of a request names an entry that is in use.
    a_r2_req_tag_in_use: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> st_q.valid[mem_req_tag]);

    // R7: a new line cannot be taken with every entry in use.
    a_r7_full_blocks_new: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !hit && (&st_q.valid)) |-> miss_stall);

    // R8: a fill to a live entry frees it.
    a_r8_fill_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && st_q.valid[fill_tag]) |=> !st_q.valid[$past(fill_tag)]);

    // R9: a fill naming a free entry writes nothing back.
    a_r9_stray_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !st_q.valid[fill_tag]) |=> (wb_en == '0));

    // R11: a miss to a line being filled now is refused.
    a_r11_fill_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && hit && fill_valid && (fill_tag == hit_idx)) |-> miss_stall);

    // R3: no two live entries hold the same line (merging keeps lines unique).
    for (genvar i = 0; i < N_ENT; i++) begin : g_uniq_i
        for (genvar j = i + 1; j < N_ENT; j++) begin : g_uniq_j
            a_r3_unique_lines: assert property (@(posedge clk) disable iff (!rst_n)
                !(st_q.valid[i] && st_q.valid[j] && (st_q.line[i] == st_q.line[j])));
        end
    end

    // R8: every written-back register already reads full.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_wb_full
        a_r8_wb_reg_full: assert property (@(posedge clk) disable iff (!rst_n)
            wb_en[w] |-> !empty_vec[st_q.wb_reg[w]]);
    end

endmodule

// File: tb/mshr_file_tb.sv
module mshr_file_tb_top;

    localparam int NE = 4;
    localparam int NW = 8;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int AW = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            miss_valid = 1'b0;
    logic [AW-1:0]   miss_line = '0;
    logic [2:0]      miss_word = '0;
    logic [4:0]      miss_dest = '0;
    logic            miss_stall;
    logic            mem_req_valid;
    logic [AW-1:0]   mem_req_line;
    logic [1:0]      mem_req_tag;
    logic            fill_valid = 1'b0;
    logic [1:0]      fill_tag = '0;
    logic [NW*DW-1:0] fill_data = '0;
    logic [NW-1:0]   wb_en;
    logic [NW*5-1:0] wb_reg;
    logic [NW*DW-1:0] wb_data;
    logic [4:0]      dec_src_a = '0;
    logic [4:0]      dec_src_b = '0;
    logic            dec_stall;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Reference model.
    bit          m_valid [NE];
    logic [AW-1:0] m_line [NE];
    bit          m_sv    [NE][NW];
    logic [4:0]  m_sreg  [NE][NW];
    bit          m_empty [NR];

    always #5 clk = ~clk;

    mshr_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word),
        .miss_dest(miss_dest), .miss_stall(miss_stall),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_stall(dec_stall)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [NW*DW-1:0] rnd_line_data();
        logic [NW*DW-1:0] d;
        for (int i = 0; i < NW; i++) d[i*DW +: DW] = $urandom;
        return d;
    endfunction

    // One cycle: inputs are already applied at a falling edge.
    task automatic run_cycle();
        bit hit, anyfree, live, stall, e_req;
        int hidx, fidx;
        string why;
        logic [AW-1:0] e_line;
        logic [1:0] e_tag;
        logic [NW-1:0] e_en;
        logic [4:0] e_reg [NW];
        logic [DW-1:0] e_dat [NW];
        #1;
        hit = 0; hidx = 0; anyfree = 0; fidx = 0;
        for (int e = 0; e < NE; e++) if (m_valid[e] && m_line[e] == miss_line) begin hit = 1; hidx = e; end
        for (int e = NE - 1; e >= 0; e--) if (!m_valid[e]) begin anyfree = 1; fidx = e; end
        live = fill_valid && m_valid[fill_tag];
        stall = 0;
        why = "R12 idle cycle";
        if (miss_valid) begin
            if (m_empty[miss_dest]) begin stall = 1; why = "R10 pending destination refused"; end
            else if (hit && m_sv[hidx][miss_word]) begin stall = 1; why = "R6 busy word refused"; end
            else if (hit && live && fill_tag == hidx) begin stall = 1; why = "R11 fill collision refused"; end
            else if (!hit && !anyfree) begin stall = 1; why = "R7 full file refused"; end
            else if (hit) why = "R3 merge accepted";
            else why = "R2 allocation accepted";
        end
        chk(miss_stall === stall, why, miss_stall, stall);
        chk(dec_stall === (m_empty[dec_src_a] | m_empty[dec_src_b]), "R5 decode query",
            dec_stall, m_empty[dec_src_a] | m_empty[dec_src_b]);

        e_en = '0; e_req = 0; e_line = '0; e_tag = '0;
        for (int w = 0; w < NW; w++) begin e_reg[w] = '0; e_dat[w] = '0; end
        if (live) begin
            for (int w = 0; w < NW; w++) if (m_sv[fill_tag][w]) begin
                e_en[w] = 1; e_reg[w] = m_sreg[fill_tag][w];
                e_dat[w] = fill_data[w*DW +: DW];
                m_empty[m_sreg[fill_tag][w]] = 0;
                m_sv[fill_tag][w] = 0;
            end
            m_valid[fill_tag] = 0;
        end
        if (miss_valid && !stall) begin
            if (hit) begin
                m_sv[hidx][miss_word] = 1; m_sreg[hidx][miss_word] = miss_dest;
            end else begin
                m_valid[fidx] = 1; m_line[fidx] = miss_line;
                for (int w = 0; w < NW; w++) m_sv[fidx][w] = 0;
                m_sv[fidx][miss_word] = 1; m_sreg[fidx][miss_word] = miss_dest;
                e_req = 1; e_line = miss_line; e_tag = 2'(fidx);
            end
            m_empty[miss_dest] = 1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(mem_req_valid === e_req,
            stall ? "R12 refused miss requests nothing" : "R4 request only on allocation",
            mem_req_valid, e_req);
        if (e_req) begin
            chk(mem_req_line === e_line, "R2 request line", mem_req_line, e_line);
            chk(mem_req_tag === e_tag, "R2 request tag lowest free", mem_req_tag, e_tag);
        end
        chk(wb_en === e_en, (fill_valid && !live) ? "R9 stray fill ignored" : "R8 writeback mask",
            wb_en, e_en);
        for (int w = 0; w < NW; w++) if (e_en[w]) begin
            chk(wb_reg[w*5 +: 5] === e_reg[w], "R8 writeback register", wb_reg[w*5 +: 5], e_reg[w]);
            chk(wb_data[w*DW +: DW] === e_dat[w], "R8 writeback data", wb_data[w*DW +: DW], e_dat[w]);
        end
    endtask

    task automatic drive(input bit mv, input logic [AW-1:0] ln, input int w, input int d,
                         input bit fv, input int tg, input int a, input int b);
        miss_valid = mv; miss_line = ln; miss_word = 3'(w); miss_dest = 5'(d);
        fill_valid = fv; fill_tag = 2'(tg); fill_data = rnd_line_data();
        dec_src_a = 5'(a); dec_src_b = 5'(b);
        run_cycle();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int e = 0; e < NE; e++) begin
            m_valid[e] = 0; m_line[e] = '0;
            for (int w = 0; w < NW; w++) begin m_sv[e][w] = 0; m_sreg[e][w] = '0; end
        end
        for (int r = 0; r < NR; r++) m_empty[r] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset.
        chk(miss_stall === 1'b0, "R1 no refusal after reset", miss_stall, 0);
        chk(dec_stall === 1'b0, "R1 all registers full after reset", dec_stall, 0);
        chk(mem_req_valid === 1'b0, "R1 no request after reset", mem_req_valid, 0);
        chk(wb_en === '0, "R1 no writeback after reset", wb_en, 0);

        // Directed: fill all entries.
        for (int i = 0; i < NE; i++) drive(1, 26'h100 + 26'(i), i, 1 + i, 0, 0, 0, 0);
        drive(1, 26'h200, 0, 10, 0, 0, 1, 0);   // R7 refused, R5 decode sees reg 1
        drive(1, 26'h100, 5, 11, 0, 0, 0, 0);   // R3 merge into entry 0
        drive(1, 26'h100, 5, 12, 0, 0, 0, 0);   // R6 same word busy
        drive(1, 26'h101, 6, 1, 0, 0, 0, 0);    // R10 destination pending
        drive(0, 0, 0, 0, 0, 0, 11, 12);        // R5 decode query
        drive(1, 26'h102, 7, 13, 1, 2, 0, 0);   // R11 collision, fill entry 2
        drive(0, 0, 0, 0, 1, 2, 3, 13);         // R9 stray fill to freed entry
        drive(1, 26'h200, 0, 10, 0, 0, 0, 0);   // R2 reuses entry 2
        drive(0, 0, 0, 0, 1, 0, 1, 11);
        drive(0, 0, 0, 0, 1, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 3, 0, 0);
        drive(0, 0, 0, 0, 1, 2, 10, 0);

        // Random phase over a small pool of lines.
        for (int n = 0; n < 4000; n++) begin
            drive(($urandom % 100) < 55, 26'h300 + 26'($urandom % 6), $urandom % NW, $urandom % NR,
                  ($urandom % 100) < 30, $urandom % NE, $urandom % NR, $urandom % NR);
        end
        for (int t = 0; t < NE; t++) drive(0, 0, 0, 0, 1, t, 0, 0);

        summary();
        $finish;
    end

endmodule